// File: doc/BRIEF.md
# OTP ROM Read Port with Identify Mode

This block is a synthesizable, clocked model of the read side of a byte-wide one-time-programmable ROM. It has 262,144 words of 8 bits and an 18-bit address. Two control inputs select it, both active low: a chip enable and an output enable. A flag marks that the identify voltage is on address line 9. The data bus is modelled as an 8-bit value plus a drive flag, which stands in for tri-state control. The array contents come from a parameterised fill pattern computed from the address, so no large memory is built.

The analog delays of a real part are modelled as clock-cycle latencies. There is one latency for the address, one for the chip enable and one for the output enable. The read timer is a four-state machine. `ST_STANDBY` holds while the chip enable is high. The `wake` transition leads into `ST_ACCESS`, where the address and chip-enable latencies count. The `settled` transition leads to `ST_ARMED`, where the output-enable latency is still pending or the output enable is high. The `release` transition leads to `ST_DRIVE`, where the output is valid. From any enabled state, the `restart` transition goes back to `ST_ACCESS` when the address or identify flag changes. From any state, the `sleep` transition goes to `ST_STANDBY` when the chip enable goes high. From `ST_DRIVE`, the `hold_off` transition goes to `ST_ARMED` when the output enable goes high.

While the identify flag is high, the port returns fixed identifier bytes chosen by the two lowest address bits. An illegal address in this mode gives 8'hFF and raises a violation flag.

Top module: `otp_rom_port`

## Requirements
- R1: Outside identify mode, a valid read returns FILL ^ addr[7:0] ^ addr[15:8] ^ {6'b0, addr[17:16]}, with FILL = 8'hA5 by default. For example, address 18'h12345 reads 8'hC2.
- R2: `dout_en` is high in the same cycle exactly when `ce_n` = 0 and `oe_n` = 0.
- R3: While `ce_n` = 1, `dout_en`, `data_valid` and `dout` are all 0 in the same cycle, whatever `oe_n` is.
- R4: `data_valid` rises only after a clock edge at which three counts are met: at least ACC_LAT consecutive edges with `ce_n` low and the same {id_hv, addr}, at least CE_LAT edges with `ce_n` low, and at least OE_LAT edges with both enables low. The defaults are 4, 4 and 2.
- R5: If the address or the identify flag changes while `ce_n` is low, `data_valid` is 0 from the next edge until ACC_LAT stable edges have passed again.
- R6: After `oe_n` falls, with the access latency already met, `data_valid` stays 0 for OE_LAT edges and then rises.
- R7: `dout` carries the byte captured at the last edge while `data_valid` is 1, and is 8'h00 otherwise.
- R8: With `id_hv` = 1, addr[1:0] selects the identifier: 00 gives 8'h37, 01 gives 8'h64 and 10 gives 8'h7F.
- R9: Every identifier byte has odd parity, with bit 7 as the parity bit.
- R10: With `id_hv` = 1 and `ce_n` = 0, an address with addr[1:0] = 11, or with any bit other than bits 0, 1 and 9 set, reads 8'hFF, and `id_violation` is 1 from the next edge. Otherwise `id_violation` is 0.
- R11: During reset, with both enables high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| oe_n | input | 1 | Output enable, active low |
| id_hv | input | 1 | High voltage present on address line 9 (identify mode) |
| addr | input | AW (18) | Word address |
| dout | output | 8 | Read data, 0 when not valid |
| dout_en | output | 1 | Bus drive flag (low means high impedance) |
| data_valid | output | 1 | Read data is settled and valid |
| id_violation | output | 1 | Illegal address seen in identify mode |

## Verification
`dout_en` follows the enable pins in the same cycle. `data_valid`, `dout` and `id_violation` come from registers, so they change one edge after the last input that affects them. With stable inputs, `data_valid` first rises after the ACC_LAT-th edge (four by default). After an output-enable fall with the access latency already met, it rises after the OE_LAT-th edge (two by default). The bench drives inputs on the falling edge and compares every output one nanosecond later against a behavioural model, which updates its counters on the rising edge. Directed checks wait for an exact number of falling edges: one fewer than the latency must show no valid data, and the latency itself must show the expected byte.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_ACCESS,
        ST_ARMED,
        ST_DRIVE
    } rd_state_e;

    localparam logic [DW-1:0] ID_MAKER = 8'h37;
    localparam logic [DW-1:0] ID_PART  = 8'h64;
    localparam logic [DW-1:0] ID_CONT  = 8'h7F;
    localparam logic [DW-1:0] ID_BAD   = 8'hFF;

endpackage

// File: rtl/otp_rom_array.sv
module otp_rom_array
    import otp_rom_pkg::*;
#(
    parameter int            AW   = 18,
    parameter logic [DW-1:0] FILL = 8'hA5
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    // Fold the address, one byte at a time, onto the fill byte.
    always_comb begin
        data = FILL;
        for (int i = 0; i < AW; i++) begin
            data[i % DW] = data[i % DW] ^ addr[i];
        end
    end

endmodule

// File: rtl/otp_rom_id.sv
module otp_rom_id
    import otp_rom_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] code,
    output logic          bad
);

    localparam logic [AW-1:0] KEEP = AW'(10'h203);

    logic [DW-1:0] sel_code;

    always_comb begin
        unique case (addr[1:0])
            2'b00:   sel_code = ID_MAKER;
            2'b01:   sel_code = ID_PART;
            2'b10:   sel_code = ID_CONT;
            default: sel_code = ID_BAD;
        endcase
        bad  = (addr[1:0] == 2'b11) || ((addr & ~KEEP) != '0);
        code = bad ? ID_BAD : sel_code;
    end

    // R9
    always_comb begin
        if (!bad) begin
            id_odd_parity_chk: assert (^code == 1'b1)
                else $error("identifier byte without odd parity");
        end
    end

endmodule

// File: rtl/otp_rom_timer.sv
module otp_rom_timer
    import otp_rom_pkg::*;
#(
    parameter int KW      = 19,
    parameter int ACC_LAT = 4,
    parameter int CE_LAT  = 4,
    parameter int OE_LAT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [KW-1:0] key,
    output logic          drive
);

    localparam int MAXL = (ACC_LAT > CE_LAT)
                        ? ((ACC_LAT > OE_LAT) ? ACC_LAT : OE_LAT)
                        : ((CE_LAT > OE_LAT) ? CE_LAT : OE_LAT);
    localparam int CW = $clog2(MAXL + 2);
    localparam logic [CW-1:0] CAP   = CW'(MAXL);
    localparam logic [CW-1:0] ACC_T = CW'(ACC_LAT);
    localparam logic [CW-1:0] CE_T  = CW'(CE_LAT);
    localparam logic [CW-1:0] OE_T  = CW'(OE_LAT);

    rd_state_e     state, state_n;
    logic [KW-1:0] key_q;
    logic [CW-1:0] addr_cnt, ce_cnt, oe_cnt;
    logic [CW-1:0] addr_cnt_n, ce_cnt_n, oe_cnt_n;
    logic          access_ok, oe_ok;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
        return (v == CAP) ? v : v + 1'b1;
    endfunction

    always_comb begin
        addr_cnt_n = ce_n ? '0 : ((key != key_q) ? CW'(1) : bump(addr_cnt));
        ce_cnt_n   = ce_n ? '0 : bump(ce_cnt);
        oe_cnt_n   = (ce_n || oe_n) ? '0 : bump(oe_cnt);
        access_ok  = (addr_cnt_n >= ACC_T) && (ce_cnt_n >= CE_T);
        oe_ok      = !oe_n && (oe_cnt_n >= OE_T);
    end

    // Next state: sleep / wake / restart / settled / release / hold_off
    always_comb begin
        unique casez ({ce_n, access_ok, oe_ok})
            3'b1??:  state_n = ST_STANDBY;
            3'b00?:  state_n = ST_ACCESS;
            3'b010:  state_n = ST_ARMED;
            3'b011:  state_n = ST_DRIVE;
            default: state_n = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_STANDBY;
            key_q    <= '0;
            addr_cnt <= '0;
            ce_cnt   <= '0;
            oe_cnt   <= '0;
        end else begin
            state    <= state_n;
            key_q    <= key;
            addr_cnt <= addr_cnt_n;
            ce_cnt   <= ce_cnt_n;
            oe_cnt   <= oe_cnt_n;
        end
    end

    always_comb drive = (state == ST_DRIVE);

    // R5
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ACC_LAT > 1 && !ce_n && key != $past(key)) |=> (state != ST_DRIVE))
        else $error("drive state reached right after an address change");

    // R3
    standby_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (state == ST_STANDBY))
        else $error("not in standby after chip enable went high");

endmodule

// File: rtl/otp_rom_port.sv
module otp_rom_port
    import otp_rom_pkg::*;
#(
    parameter int            AW      = 18,
    parameter int            ACC_LAT = 4,
    parameter int            CE_LAT  = 4,
    parameter int            OE_LAT  = 2,
    parameter logic [DW-1:0] FILL    = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          id_hv,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          data_valid,
    output logic          id_violation
);

    logic [AW:0]   key;
    logic [DW-1:0] arr_byte, id_byte, data_q;
    logic          id_bad, viol_q, mode_q, drive;

    always_comb key = {id_hv, addr};

    otp_rom_array #(.AW(AW), .FILL(FILL)) u_array (
        .addr (addr),
        .data (arr_byte)
    );

    otp_rom_id #(.AW(AW)) u_id (
        .addr (addr),
        .code (id_byte),
        .bad  (id_bad)
    );

    otp_rom_timer #(
        .KW(AW + 1), .ACC_LAT(ACC_LAT), .CE_LAT(CE_LAT), .OE_LAT(OE_LAT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .key   (key),
        .drive (drive)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            viol_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            data_q <= id_hv ? id_byte : arr_byte;
            viol_q <= !ce_n && id_hv && id_bad;
            mode_q <= id_hv;
        end
    end

    always_comb begin
        dout_en      = !ce_n && !oe_n;
        data_valid   = drive && dout_en;
        dout         = data_valid ? data_q : '0;
        id_violation = viol_q;
    end

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!data_valid && dout == '0 && !dout_en))
        else $error("bus active during standby");

    // R6
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $fell(oe_n)) |-> !data_valid)
        else $error("valid data right at output enable fall");

    // R9
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && mode_q && !id_violation) |-> (^dout == 1'b1))
        else $error("identify read with even parity");

    // R10
    id_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && id_violation) |-> (dout == ID_BAD))
        else $error("illegal identify read not all ones");

endmodule

// File: tb/tb_otp_rom_port.sv
module tb_otp_rom_port;

    localparam int AW = 18;
    localparam int ACC = 4;
    localparam int CEL = 4;
    localparam int OEL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dout;
    logic          dout_en, data_valid, id_violation;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    otp_rom_port dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .id_hv(id_hv),
        .addr(addr), .dout(dout), .dout_en(dout_en), .data_valid(data_valid),
        .id_violation(id_violation)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return 8'hA5 ^ a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction

    function automatic logic id_illegal(input logic [AW-1:0] a);
        return (a[1:0] == 2'b11) || ((a & ~18'h00203) != 18'h0);
    endfunction

    function automatic logic [7:0] id_code(input logic [AW-1:0] a);
        if (id_illegal(a)) return 8'hFF;
        case (a[1:0])
            2'b00:   return 8'h37;
            2'b01:   return 8'h64;
            default: return 8'h7F;
        endcase
    endfunction

    // behavioural reference
    int          s_m = 0, c_m = 0, o_m = 0;
    logic [AW:0] pkey = '0;
    logic        valid_m = 0, viol_m = 0;
    logic [7:0]  data_m = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_m = 0; c_m = 0; o_m = 0; pkey = '0;
            valid_m = 0; viol_m = 0; data_m = 0;
        end else begin
            if (ce_n) s_m = 0;
            else if ({id_hv, addr} != pkey) s_m = 1;
            else if (s_m < 100) s_m++;
            pkey = {id_hv, addr};
            c_m = ce_n ? 0 : ((c_m < 100) ? c_m + 1 : c_m);
            o_m = (ce_n || oe_n) ? 0 : ((o_m < 100) ? o_m + 1 : o_m);
            valid_m = !ce_n && !oe_n && s_m >= ACC && c_m >= CEL && o_m >= OEL;
            data_m  = id_hv ? id_code(addr) : pat(addr);
            viol_m  = !ce_n && id_hv && id_illegal(addr);
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
        end
    endtask

    // compare every clock, 1 ns after the falling edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n) begin
                logic ex_en, ex_v;
                ex_en = !ce_n && !oe_n;
                ex_v  = valid_m && ex_en;
                chk(8'(dout_en), 8'(ex_en), "R2 dout_en model");
                chk(8'(data_valid), 8'(ex_v), "R4 data_valid model");
                chk(dout, ex_v ? data_m : 8'h00, "R7 dout model");
                chk(8'(id_violation), 8'(viol_m), "R10 id_violation model");
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drive_in(input logic c, input logic o, input logic h, input logic [AW-1:0] a);
        @(negedge clk);
        ce_n = c; oe_n = o; id_hv = h; addr = a;
    endtask

    initial begin
        // R11 reset state
        hold(3);
        chk(dout, 8'h00, "R11 dout in reset");
        chk(8'(dout_en), 8'h00, "R11 dout_en in reset");
        chk(8'(data_valid), 8'h00, "R11 data_valid in reset");
        chk(8'(id_violation), 8'h00, "R11 id_violation in reset");
        @(negedge clk); rst_n = 1'b1;
        hold(2);

        // R4 / R1 array read
        drive_in(1'b0, 1'b0, 1'b0, 18'h12345);
        #1 chk(8'(dout_en), 8'h01, "R2 dout_en same cycle");
        hold(3);
        chk(8'(data_valid), 8'h00, "R4 not valid after 3 edges");
        hold(1);
        chk(8'(data_valid), 8'h01, "R4 valid after 4 edges");
        chk(dout, 8'hC2, "R1 array byte at 12345");

        // R5 address change restarts
        drive_in(1'b0, 1'b0, 1'b0, 18'h3FFFF);
        hold(1);
        chk(8'(data_valid), 8'h00, "R5 valid drops after address change");
        hold(2);
        chk(8'(data_valid), 8'h00, "R5 still counting");
        hold(1);
        chk(8'(data_valid), 8'h01, "R5 valid again");
        chk(dout, 8'hA6, "R1 array byte at 3FFFF");

        // R3 standby ignores oe_n
        drive_in(1'b1, 1'b0, 1'b0, 18'h3FFFF);
        #1;
        chk(8'(dout_en), 8'h00, "R3 dout_en in standby");
        chk(8'(data_valid), 8'h00, "R3 data_valid in standby");
        chk(dout, 8'h00, "R3 dout in standby");

        // R2 / R6 output enable latency
        drive_in(1'b0, 1'b1, 1'b0, 18'h00ABC);
        hold(5);
        chk(8'(dout_en), 8'h00, "R2 dout_en with oe_n high");
        chk(8'(data_valid), 8'h00, "R7 no valid with oe_n high");
        drive_in(1'b0, 1'b0, 1'b0, 18'h00ABC);
        #1 chk(8'(data_valid), 8'h00, "R6 not valid at oe fall");
        hold(1);
        chk(8'(data_valid), 8'h00, "R6 not valid after 1 edge");
        hold(1);
        chk(8'(data_valid), 8'h01, "R6 valid after 2 edges");
        chk(dout, pat(18'h00ABC), "R7 dout after oe latency");

        // R8 / R9 identify codes
        drive_in(1'b0, 1'b0, 1'b1, 18'h00200);
        hold(4);
        chk(dout, 8'h37, "R8 maker code");
        chk(8'(^dout), 8'h01, "R9 maker parity");
        drive_in(1'b0, 1'b0, 1'b1, 18'h00201);
        hold(4);
        chk(dout, 8'h64, "R8 part code");
        chk(8'(^dout), 8'h01, "R9 part parity");
        drive_in(1'b0, 1'b0, 1'b1, 18'h00002);
        hold(4);
        chk(dout, 8'h7F, "R8 continuation code");
        chk(8'(^dout), 8'h01, "R9 continuation parity");
        chk(8'(id_violation), 8'h00, "R10 no violation on legal id");

        // R10 violations
        drive_in(1'b0, 1'b0, 1'b1, 18'h00203);
        hold(1);
        chk(8'(id_violation), 8'h01, "R10 violation on select 11");
        hold(3);
        chk(dout, 8'hFF, "R10 select 11 reads FF");
        drive_in(1'b0, 1'b0, 1'b1, 18'h00600);
        hold(4);
        chk(8'(id_violation), 8'h01, "R10 violation on bit 10");
        chk(dout, 8'hFF, "R10 bit 10 reads FF");
        drive_in(1'b1, 1'b0, 1'b1, 18'h00203);
        hold(1);
        chk(8'(id_violation), 8'h00, "R10 no violation in standby");
        drive_in(1'b0, 1'b0, 1'b0, 18'h00203);
        hold(1);
        chk(8'(id_violation), 8'h00, "R10 no violation outside identify");
        hold(4);
        chk(dout, pat(18'h00203), "R1 array read after identify");

        hold(3);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule